// File: doc/BRIEF.md
# SCSI Bus-Master DMA Channel Controller

This block is a single DMA channel placed between a host register port and a SCSI protocol core. Host software programs a start byte count, a start address and a start descriptor-list address. It then writes a command word. The low two bits of that word select one of four operations: idle, flush, abort and start. A start loads the working registers from the start registers, clears the status flags and enables transfers.

The protocol core asks for data movement with a valid/ready stream of requests. Each request carries a byte length and a direction. The channel checks the direction against the programmed direction and silently drops a request that disagrees. For a matching request it clamps the length to the remaining byte count, advances the working count and address, and emits one memory request on a second valid/ready stream. Back-pressure rules:
- The request stream's ready is high only while the memory output slot is empty or is being drained in the same cycle.
- A pending memory request holds its address, length and direction until it is accepted.

The channel watches the core's interrupt line and keeps six status flags. It drives one level interrupt towards the host. A control bit in a separate bus-control register selects how the error, abort and done flags are cleared: either by writing ones, or as a side effect of reading the status slot.

Top module: `scsi_dma_chan`

## Requirements
- R1: After reset the command slot reads 0, the working count reads 0, the working address reads 0xFFFFFFFF, the working list address reads 0xFFFFFFFD, the status reads 0, the bus-control slot reads 0, and `irq` and `xfer_en` are low.
- R2: Register slots are selected by `reg_sel`:
  - 0 command, 1 start count, 2 start address, 3 working count, 4 working address, 5 status, 6 start list address, 7 working list address, 8 bus control.
  - Other selects read 0. Slots 0, 1, 2, 6 and 8 read back the last value written.
  - `reg_rdata` is combinational in the cycle of `reg_rd_en`.
- R3: Command bits [1:0] = 3 (start) copies start count, start address and start list address into the working registers, clears all status bits, and sets `xfer_en` from the next cycle.
- R4: Operation 2 (abort) raises `core_cancel` for exactly one cycle, in the cycle after the command write. Operation 0 (idle) clears `xfer_en`. Abort and flush leave `xfer_en` unchanged.
- R5: Operation 1 (flush) sets status bit 5 and changes no other status bit.
- R6: An accepted request whose direction matches command bit 7 produces one memory request with the current working address and a length of min(request length, working count). The working count then drops by that length and the working address rises by it.
- R7: An accepted request whose direction (`req_dir`, 1 = device to memory) differs from command bit 7 produces no memory request and leaves both working registers unchanged.
- R8: While `mem_valid` is high and `mem_ready` is low:
  - `req_ready` is low;
  - `mem_valid`, `mem_addr` and `mem_len` hold their values.
- R9: `irq` equals status bit 4, ORed with status bit 3 only when command bit 6 is set.
- R10: A rising `core_irq` sets status bit 4. If the current operation is start and the working count is 0, it also sets status bit 3 (done) in the same update. A falling `core_irq` clears only bit 4.
- R11: With bus-control bit 24 set:
  - a status write clears bits 1, 2 and 3 where the written data has ones, and does not touch bit 4;
  - a status read clears nothing.
- R12: With bus-control bit 24 clear:
  - status writes have no effect;
  - a status read returns the current value and then clears bits 1, 2 and 3.
- R13: Writes to slots 3, 4 and 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (status read side effects) |
| reg_sel | input | 4 | Register slot select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| core_irq | input | 1 | Interrupt level from the SCSI core |
| core_cancel | output | 1 | One-cycle cancel request to the core |
| xfer_en | output | 1 | Transfer enable towards the core |
| req_valid | input | 1 | Transfer request valid |
| req_ready | output | 1 | Transfer request ready |
| req_len | input | LEN_W | Requested byte length |
| req_dir | input | 1 | Request direction, 1 = device to memory |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request ready |
| mem_addr | output | 32 | Memory request address |
| mem_len | output | 32 | Memory request byte length after clamping |
| mem_wr | output | 1 | Memory request direction, 1 = write to memory |
| irq | output | 1 | Level interrupt to the host |

## Verification
The transfer path is exercised with four request patterns:
- A request shorter than the remaining count shows plain address and count stepping.
- A request in the wrong direction shows that drops touch neither the output stream nor the counters.
- A request larger than the remainder shows the clamp.
- Two back-to-back requests with the memory side stalled show that back-pressure holds the pending request steady and that ordering is kept.

Status clearing is tried in both bus-control modes. The same write and read sequences are used in each, so a swapped mode or a wrong clear mask is caught. The core interrupt is toggled with zero and non-zero remaining counts, which tells the done-on-interrupt rule apart from a plain interrupt relay.

// File: rtl/scsi_dma_pkg.sv
package scsi_dma_pkg;
  localparam int REG_W    = 32;
  localparam int SLOT_CNT = 9;
  localparam int SEL_W    = $clog2(SLOT_CNT);
  localparam int STAT_W   = 6;

  localparam logic [SEL_W-1:0] SLOT_CMD    = SEL_W'(0);
  localparam logic [SEL_W-1:0] SLOT_SCNT   = SEL_W'(1);
  localparam logic [SEL_W-1:0] SLOT_SADDR  = SEL_W'(2);
  localparam logic [SEL_W-1:0] SLOT_WCNT   = SEL_W'(3);
  localparam logic [SEL_W-1:0] SLOT_WADDR  = SEL_W'(4);
  localparam logic [SEL_W-1:0] SLOT_STAT   = SEL_W'(5);
  localparam logic [SEL_W-1:0] SLOT_SLIST  = SEL_W'(6);
  localparam logic [SEL_W-1:0] SLOT_WLIST  = SEL_W'(7);
  localparam logic [SEL_W-1:0] SLOT_BUSCTL = SEL_W'(8);

  // status bit positions
  localparam int ST_PWDN  = 0;
  localparam int ST_ERR   = 1;
  localparam int ST_ABRT  = 2;
  localparam int ST_DONE  = 3;
  localparam int ST_CORE  = 4;
  localparam int ST_FLUSH = 5;

  // command and bus-control bit positions
  localparam int CMD_DONE_IE = 6;
  localparam int CMD_DIR     = 7;
  localparam int BUS_W1C     = 24;

  localparam logic [REG_W-1:0] WADDR_RST = '1;
  localparam logic [REG_W-1:0] WLIST_RST = 32'hFFFF_FFFD;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_FLUSH = 2'd1,
    OP_ABORT = 2'd2,
    OP_START = 2'd3
  } dma_op_e;
endpackage

// File: rtl/scsi_dma_regs.sv
module scsi_dma_regs
  import scsi_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [SEL_W-1:0]  sel,
  input  logic [REG_W-1:0]  wdata,
  input  logic [REG_W-1:0]  wcnt,
  input  logic [REG_W-1:0]  waddr,
  input  logic [REG_W-1:0]  wlist,
  input  logic [STAT_W-1:0] stat,
  output logic [REG_W-1:0]  rdata,
  output logic [REG_W-1:0]  start_cnt,
  output logic [REG_W-1:0]  start_addr,
  output logic [REG_W-1:0]  start_list,
  output dma_op_e           op,
  output logic              dir_cfg,
  output logic              done_ie,
  output logic              w1c_mode,
  output logic              start_pulse,
  output logic              flush_pulse,
  output logic              stat_wr,
  output logic              stat_rd,
  output logic              core_cancel,
  output logic              xfer_en
);
  logic [REG_W-1:0] cmd_q;
  logic [REG_W-1:0] busctl_q;
  logic             cmd_wr;
  dma_op_e          op_w;
  logic             abort_pulse;
  logic             idle_pulse;

  assign cmd_wr      = wr_en && (sel == SLOT_CMD);
  assign op_w        = dma_op_e'(wdata[1:0]);
  assign start_pulse = cmd_wr && (op_w == OP_START);
  assign flush_pulse = cmd_wr && (op_w == OP_FLUSH);
  assign abort_pulse = cmd_wr && (op_w == OP_ABORT);
  assign idle_pulse  = cmd_wr && (op_w == OP_IDLE);
  assign stat_wr     = wr_en && (sel == SLOT_STAT);
  assign stat_rd     = rd_en && (sel == SLOT_STAT);

  assign op       = dma_op_e'(cmd_q[1:0]);
  assign dir_cfg  = cmd_q[CMD_DIR];
  assign done_ie  = cmd_q[CMD_DONE_IE];
  assign w1c_mode = busctl_q[BUS_W1C];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q       <= '0;
      start_cnt   <= '0;
      start_addr  <= '0;
      start_list  <= '0;
      busctl_q    <= '0;
      core_cancel <= 1'b0;
      xfer_en     <= 1'b0;
    end else begin
      core_cancel <= abort_pulse;
      if (start_pulse)     xfer_en <= 1'b1;
      else if (idle_pulse) xfer_en <= 1'b0;
      if (wr_en) begin
        case (sel)
          SLOT_CMD:    cmd_q      <= wdata;
          SLOT_SCNT:   start_cnt  <= wdata;
          SLOT_SADDR:  start_addr <= wdata;
          SLOT_SLIST:  start_list <= wdata;
          SLOT_BUSCTL: busctl_q   <= wdata;
          default:     ;
        endcase
      end
    end
  end

  always_comb begin
    case (sel)
      SLOT_CMD:    rdata = cmd_q;
      SLOT_SCNT:   rdata = start_cnt;
      SLOT_SADDR:  rdata = start_addr;
      SLOT_WCNT:   rdata = wcnt;
      SLOT_WADDR:  rdata = waddr;
      SLOT_STAT:   rdata = {{(REG_W-STAT_W){1'b0}}, stat};
      SLOT_SLIST:  rdata = start_list;
      SLOT_WLIST:  rdata = wlist;
      SLOT_BUSCTL: rdata = busctl_q;
      default:     rdata = '0;
    endcase
  end

  // R4: cancel is a single-cycle pulse unless abort is written again
  p_cancel_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (core_cancel && !abort_pulse) |=> !core_cancel);

  // R3: a start command enables transfers in the following cycle
  p_start_enables_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> xfer_en);
endmodule

// File: rtl/scsi_dma_status.sv
module scsi_dma_status
  import scsi_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_pulse,
  input  logic              flush_pulse,
  input  logic              stat_wr,
  input  logic              stat_rd,
  input  logic [2:0]        clr_mask,
  input  logic              w1c_mode,
  input  logic              core_irq,
  input  dma_op_e           op,
  input  logic              done_ie,
  input  logic              wcnt_zero,
  output logic [STAT_W-1:0] stat,
  output logic              irq
);
  logic              core_irq_q;
  logic              irq_rise;
  logic              irq_fall;
  logic [STAT_W-1:0] stat_nxt;

  assign irq_rise = core_irq && !core_irq_q;
  assign irq_fall = !core_irq && core_irq_q;

  always_comb begin
    stat_nxt = stat;
    if (start_pulse) stat_nxt = '0;
    if (flush_pulse) stat_nxt[ST_FLUSH] = 1'b1;
    if (stat_wr && w1c_mode) stat_nxt[ST_DONE:ST_ERR] = stat_nxt[ST_DONE:ST_ERR] & ~clr_mask;
    if (stat_rd && !w1c_mode) stat_nxt[ST_DONE:ST_ERR] = '0;
    if (irq_rise) begin
      stat_nxt[ST_CORE] = 1'b1;
      if (op == OP_START && wcnt_zero) stat_nxt[ST_DONE] = 1'b1;
    end else if (irq_fall) begin
      stat_nxt[ST_CORE] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat       <= '0;
      core_irq_q <= 1'b0;
    end else begin
      stat       <= stat_nxt;
      core_irq_q <= core_irq;
    end
  end

  assign irq = stat[ST_CORE] | (done_ie & stat[ST_DONE]);

  // R5: flush always leaves the flush-complete flag set
  p_flush_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pulse |=> stat[ST_FLUSH]);

  // R10: a falling core interrupt drops the core flag
  p_fall_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fall |=> !stat[ST_CORE]);

  // R12: a read in read-clear mode leaves done low unless a new rise sets it
  p_read_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !w1c_mode && !irq_rise) |=> !stat[ST_DONE]);

  // R9: with the done enable off and no core flag, no interrupt
  p_irq_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_ie && !stat[ST_CORE]) |-> !irq);
endmodule

// File: rtl/scsi_dma_xfer.sv
module scsi_dma_xfer
  import scsi_dma_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_pulse,
  input  logic [REG_W-1:0] start_cnt,
  input  logic [REG_W-1:0] start_addr,
  input  logic [REG_W-1:0] start_list,
  input  logic             dir_cfg,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_dir,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic [REG_W-1:0] mem_addr,
  output logic [REG_W-1:0] mem_len,
  output logic             mem_wr,
  output logic [REG_W-1:0] wcnt,
  output logic [REG_W-1:0] waddr,
  output logic [REG_W-1:0] wlist
);
  localparam int PAD_W = REG_W - LEN_W;

  logic             req_fire;
  logic             take;
  logic [REG_W-1:0] len_ext;
  logic [REG_W-1:0] grant;

  assign req_ready = !mem_valid || mem_ready;
  assign req_fire  = req_valid && req_ready;
  assign take      = req_fire && (req_dir == dir_cfg);
  assign len_ext   = {{PAD_W{1'b0}}, req_len};
  assign grant     = (len_ext < wcnt) ? len_ext : wcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt  <= '0;
      waddr <= WADDR_RST;
      wlist <= WLIST_RST;
    end else if (start_pulse) begin
      wcnt  <= start_cnt;
      waddr <= start_addr;
      wlist <= start_list;
    end else if (take) begin
      wcnt  <= wcnt - grant;
      waddr <= waddr + grant;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_len   <= '0;
      mem_wr    <= 1'b0;
    end else if (take) begin
      mem_valid <= 1'b1;
      mem_addr  <= waddr;
      mem_len   <= grant;
      mem_wr    <= req_dir;
    end else if (mem_ready) begin
      mem_valid <= 1'b0;
    end
  end

  // R8: a stalled memory request holds steady
  p_mem_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_len)));

  // R6: outside a start the remaining count never grows
  p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !start_pulse |=> (wcnt <= $past(wcnt)));

  // R7: a request in the wrong direction leaves the counters alone
  p_drop_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && (req_dir != dir_cfg) && !start_pulse) |=> ($stable(wcnt) && $stable(waddr)));
endmodule

// File: rtl/scsi_dma_chan.sv
module scsi_dma_chan
  import scsi_dma_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic             reg_rd_en,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             core_irq,
  output logic             core_cancel,
  output logic             xfer_en,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_dir,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic [REG_W-1:0] mem_addr,
  output logic [REG_W-1:0] mem_len,
  output logic             mem_wr,
  output logic             irq
);
  logic [REG_W-1:0]  start_cnt, start_addr, start_list;
  logic [REG_W-1:0]  wcnt, waddr, wlist;
  logic [STAT_W-1:0] stat;
  dma_op_e           op;
  logic              dir_cfg, done_ie, w1c_mode;
  logic              start_pulse, flush_pulse, stat_wr, stat_rd;

  scsi_dma_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .rd_en(reg_rd_en),
    .sel(reg_sel), .wdata(reg_wdata), .wcnt(wcnt), .waddr(waddr),
    .wlist(wlist), .stat(stat), .rdata(reg_rdata), .start_cnt(start_cnt),
    .start_addr(start_addr), .start_list(start_list), .op(op),
    .dir_cfg(dir_cfg), .done_ie(done_ie), .w1c_mode(w1c_mode),
    .start_pulse(start_pulse), .flush_pulse(flush_pulse),
    .stat_wr(stat_wr), .stat_rd(stat_rd), .core_cancel(core_cancel),
    .xfer_en(xfer_en)
  );

  scsi_dma_status u_status (
    .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse),
    .flush_pulse(flush_pulse), .stat_wr(stat_wr), .stat_rd(stat_rd),
    .clr_mask(reg_wdata[ST_DONE:ST_ERR]), .w1c_mode(w1c_mode),
    .core_irq(core_irq), .op(op), .done_ie(done_ie),
    .wcnt_zero(wcnt == '0), .stat(stat), .irq(irq)
  );

  scsi_dma_xfer #(.LEN_W(LEN_W)) u_xfer (
    .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse),
    .start_cnt(start_cnt), .start_addr(start_addr), .start_list(start_list),
    .dir_cfg(dir_cfg), .req_valid(req_valid), .req_ready(req_ready),
    .req_len(req_len), .req_dir(req_dir), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_len(mem_len),
    .mem_wr(mem_wr), .wcnt(wcnt), .waddr(waddr), .wlist(wlist)
  );
endmodule

// File: tb/scsi_dma_chan_bench.sv
module scsi_dma_chan_bench;
  import scsi_dma_pkg::*;
  localparam int LEN_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [SEL_W-1:0] reg_sel = '0;
  logic [REG_W-1:0] reg_wdata = '0, reg_rdata;
  logic             core_irq = 1'b0, core_cancel, xfer_en;
  logic             req_valid = 1'b0, req_ready, req_dir = 1'b0;
  logic [LEN_W-1:0] req_len = '0;
  logic             mem_valid, mem_ready = 1'b1, mem_wr, irq;
  logic [REG_W-1:0] mem_addr, mem_len;

  scsi_dma_chan #(.LEN_W(LEN_W)) u_scsi_dma_chan (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  typedef struct { logic [31:0] addr; logic [31:0] len; logic wr; } mreq_t;
  mreq_t exp_q[$];
  logic [31:0] m_wcnt, m_waddr;
  logic        m_dir;

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [SEL_W-1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [SEL_W-1:0] s, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_sel = s;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd_en = 1'b0;
  endtask

  task automatic read_chk(input logic [SEL_W-1:0] s, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    reg_read(s, v);
    check_eq(tag, v, exp);
  endtask

  // driver: pushes the expected memory request when a request is accepted
  task automatic send_req(input logic [LEN_W-1:0] len, input logic dir);
    logic [31:0] g;
    @(negedge clk);
    req_valid = 1'b1; req_len = len; req_dir = dir;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    if (dir == m_dir) begin
      g = ({16'd0, len} < m_wcnt) ? {16'd0, len} : m_wcnt;
      exp_q.push_back('{m_waddr, g, dir});
      m_wcnt  = m_wcnt - g;
      m_waddr = m_waddr + g;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic set_core(input logic v);
    @(negedge clk);
    core_irq = v;
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  // monitor: pops and compares every accepted memory request
  always @(negedge clk) begin
    #2;
    if (rst_n && mem_valid && mem_ready) begin
      if (exp_q.size() == 0) begin
        check_eq("R7 unexpected memory request", mem_addr, 32'hDEAD_DEAD);
      end else begin
        mreq_t e;
        e = exp_q.pop_front();
        check_eq("R6 mem_addr", mem_addr, e.addr);
        check_eq("R6 mem_len clamp", mem_len, e.len);
        check_eq("R7 mem_wr", {31'd0, mem_wr}, {31'd0, e.wr});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1;
    check_eq("R1 irq", {31'd0, irq}, 0);
    check_eq("R1 xfer_en", {31'd0, xfer_en}, 0);
    read_chk(SLOT_CMD, 0, "R1 command");
    read_chk(SLOT_WCNT, 0, "R1 working count");
    read_chk(SLOT_WADDR, 32'hFFFF_FFFF, "R1 working address");
    read_chk(SLOT_STAT, 0, "R1 status");
    read_chk(SLOT_WLIST, 32'hFFFF_FFFD, "R1 working list");
    read_chk(SLOT_BUSCTL, 0, "R1 bus control");

    // R2/R3 program and start, device to memory
    reg_write(SLOT_SCNT, 100);
    reg_write(SLOT_SADDR, 32'h1000);
    reg_write(SLOT_SLIST, 32'h2000);
    reg_write(SLOT_CMD, 32'h83);
    m_wcnt = 100; m_waddr = 32'h1000; m_dir = 1'b1;
    check_eq("R3 xfer_en after start", {31'd0, xfer_en}, 1);
    read_chk(SLOT_CMD, 32'h83, "R2 command readback");
    read_chk(SLOT_SCNT, 100, "R2 start count readback");
    read_chk(SLOT_WCNT, 100, "R3 count copied");
    read_chk(SLOT_WADDR, 32'h1000, "R3 address copied");
    read_chk(SLOT_WLIST, 32'h2000, "R3 list copied");
    read_chk(4'd12, 0, "R2 unmapped select");

    // R6/R7 transfer patterns
    send_req(40, 1'b1);
    send_req(30, 1'b0);
    read_chk(SLOT_WCNT, 60, "R7 dropped request keeps count");
    send_req(100, 1'b1);
    read_chk(SLOT_WCNT, 0, "R6 count after clamp");
    read_chk(SLOT_WADDR, 32'h1064, "R6 address after clamp");

    // R10/R12 core interrupt with zero count, read-clear mode
    set_core(1'b1);
    check_eq("R9 irq from core flag", {31'd0, irq}, 1);
    reg_write(SLOT_STAT, 32'h08);
    read_chk(SLOT_STAT, 32'h18, "R12 write ignored / R10 done on rise");
    read_chk(SLOT_STAT, 32'h10, "R12 read cleared done");
    set_core(1'b0);
    read_chk(SLOT_STAT, 0, "R10 fall clears core flag");
    check_eq("R10 irq low after fall", {31'd0, irq}, 0);
    set_core(1'b1);
    set_core(1'b0);
    #1;
    check_eq("R9 done masked", {31'd0, irq}, 0);

    // R5 flush with done interrupt enabled
    reg_write(SLOT_CMD, 32'h41);
    #1;
    check_eq("R9 irq from done", {31'd0, irq}, 1);
    check_eq("R4 flush keeps xfer_en", {31'd0, xfer_en}, 1);
    read_chk(SLOT_STAT, 32'h28, "R5 flush sets bit 5 only");
    #1;
    check_eq("R9 irq after read clear", {31'd0, irq}, 0);
    read_chk(SLOT_STAT, 32'h20, "R12 bit 5 survives read");

    // R11 write-one-to-clear mode
    reg_write(SLOT_BUSCTL, 32'h0100_0000);
    read_chk(SLOT_BUSCTL, 32'h0100_0000, "R2 bus control readback");
    reg_write(SLOT_SCNT, 0);
    reg_write(SLOT_CMD, 32'h43);
    m_wcnt = 0; m_waddr = 32'h1000; m_dir = 1'b0;
    read_chk(SLOT_STAT, 0, "R3 start clears status");
    set_core(1'b1);
    read_chk(SLOT_STAT, 32'h18, "R11 first read");
    read_chk(SLOT_STAT, 32'h18, "R11 read does not clear");
    reg_write(SLOT_STAT, 32'h10);
    read_chk(SLOT_STAT, 32'h18, "R11 core flag not cleared by write");
    reg_write(SLOT_STAT, 32'h08);
    read_chk(SLOT_STAT, 32'h10, "R11 done cleared by write");
    set_core(1'b0);
    check_eq("R9 irq idle", {31'd0, irq}, 0);

    // R13 working registers ignore writes
    reg_write(SLOT_WCNT, 32'h55);
    reg_write(SLOT_WADDR, 32'h66);
    reg_write(SLOT_WLIST, 32'h77);
    read_chk(SLOT_WCNT, 0, "R13 working count");
    read_chk(SLOT_WADDR, 32'h1000, "R13 working address");
    read_chk(SLOT_WLIST, 32'h2000, "R13 working list");

    // R4 abort and idle
    reg_write(SLOT_CMD, 32'h42);
    #1;
    check_eq("R4 cancel pulse", {31'd0, core_cancel}, 1);
    check_eq("R4 abort keeps xfer_en", {31'd0, xfer_en}, 1);
    @(negedge clk); #1;
    check_eq("R4 cancel one cycle", {31'd0, core_cancel}, 0);
    reg_write(SLOT_CMD, 32'h00);
    check_eq("R4 idle clears xfer_en", {31'd0, xfer_en}, 0);

    // R8 back-pressure
    reg_write(SLOT_SCNT, 1000);
    reg_write(SLOT_SADDR, 32'h4000);
    reg_write(SLOT_CMD, 32'h83);
    m_wcnt = 1000; m_waddr = 32'h4000; m_dir = 1'b1;
    mem_ready = 1'b0;
    send_req(10, 1'b1);
    #1;
    check_eq("R8 req_ready low when stalled", {31'd0, req_ready}, 0);
    repeat (2) @(negedge clk);
    #1;
    check_eq("R8 mem_valid held", {31'd0, mem_valid}, 1);
    check_eq("R8 mem_addr held", mem_addr, 32'h4000);
    check_eq("R8 mem_len held", mem_len, 10);
    @(negedge clk);
    mem_ready = 1'b1;
    send_req(20, 1'b1);
    repeat (3) @(negedge clk);
    check_eq("R6 scoreboard drained", exp_q.size(), 0);
    read_chk(SLOT_WCNT, 970, "R6 count after two requests");
    read_chk(SLOT_WADDR, 32'h401E, "R6 address after two requests");

    summary();
  end
endmodule